// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block exercises an external memory through a plain synchronous request port. After a start pulse it runs a fixed series of phases. The first walks a single set bit across the data bus at word 0. The second checks each address line alone by writing a marker pattern at every power-of-two word address. The third checks for aliasing by overwriting word 0 and then rereading each power-of-two address. An optional full sweep can follow, which fills the whole array before reading any word back. When the run ends the block reports pass or fail. On a failure it keeps the first failing address, the value it expected and the value it read.

The memory port carries one access at a time. A request (`mem_we` or `mem_re`) holds its address and data steady until the memory answers with `mem_ready`. For a read, `mem_rdata` is taken in the cycle where `mem_ready` is high. A read is never issued before the write it checks has been accepted, so each write/read pair keeps its order. The pattern words are the byte 0xAA ("high") and the byte 0x55 ("low"), each repeated across the data width.

The control is one state machine. `ST_IDLE` goes to `ST_DB_WR` on start. Each access state moves on when `mem_ready` is seen:
- The data-bus phase alternates `ST_DB_WR` and `ST_DB_RD`.
- The address phase alternates `ST_AB_WR` and `ST_AB_RD`.
- The aliasing phase runs `ST_AL_WR` once, then repeats `ST_AL_RD`.
- The full sweep runs `ST_EX_WR` for every word, then `ST_EX_RD` for every word.

A read that mismatches, or the last read of the final phase, returns the machine to `ST_IDLE` with done set.

Top module: `mem_bist`

## Requirements
- R1: After reset the block is idle: busy, done and fail are 0, and neither mem_we nor mem_re is asserted.
- R2: When start is seen while idle, busy rises. For each bit i from 0 to DATA_W-1, the block writes the word with only bit i set to address 0, then reads address 0 and expects that word back.
- R3: Next, for each i from 0 to ADDR_W-1, the block writes the high pattern (byte 0xAA repeated) to address 2^i and then reads it back.
- R4: Next, the block writes the low pattern (byte 0x55 repeated) to address 0. It then reads addresses 2^0 through 2^(ADDR_W-1) in rising order and expects the high pattern at each.
- R5: The exhaustive input is sampled when start is accepted. Only if it was 1 does a full sweep follow. The sweep first writes every address in rising order, with the low pattern at even addresses and the high pattern at odd ones. It then reads every address in rising order and compares.
- R6: Testing stops at the first read mismatch. The block then sets done and fail, and captures that read's address in fail_addr, its expected value in fail_exp and the value read in fail_got. No further access is issued.
- R7: A request holds mem_addr, mem_wdata, mem_we and mem_re steady until mem_ready. mem_we and mem_re are never both asserted. Each cycle with a request and mem_ready completes exactly one access.
- R8: done, fail, fail_addr, fail_exp and fail_got hold their values until the next accepted start, which clears all of them to 0.
- R9: A start that arrives while busy is ignored. The run continues unchanged, and its exhaustive value is not resampled.
- R10: On a run with no mismatch, done rises with fail at 0 when the last read of the last scheduled phase completes. busy is 0 whenever done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test run when idle |
| exhaustive | input | 1 | Request the full sweep, sampled at start |
| mem_addr | output | ADDR_W | Word address of the current access |
| mem_wdata | output | DATA_W | Write data |
| mem_we | output | 1 | Write request |
| mem_re | output | 1 | Read request |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts or answers the current request |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| fail | output | 1 | Last run found a mismatch |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_exp | output | DATA_W | Expected value at the first mismatch |
| fail_got | output | DATA_W | Value read at the first mismatch |

## Verification
The hardest case to reach is a fault that only the aliasing phase exposes. In that case every earlier write/read pair passes, and the failure comes from a write to a different address. The bench gets there with a responder memory that drops one address bit. The high pattern written to 2^k then lands on word 0, and it survives until the low-pattern write replaces it. Stuck data bits and single corrupt cells, with random ready stalls, drive the other phases. Each run's access sequence is compared against a sequence predicted for the same fault.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DB_WR,
        ST_DB_RD,
        ST_AB_WR,
        ST_AB_RD,
        ST_AL_WR,
        ST_AL_RD,
        ST_EX_WR,
        ST_EX_RD
    } step_e;
endpackage

// File: rtl/mbist_pattern.sv
module mbist_pattern
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 9
) (
    input  step_e             step,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int NBYTES = DATA_W / 8;
    localparam logic [DATA_W-1:0] PAT_HI = {NBYTES{8'hAA}};
    localparam logic [DATA_W-1:0] PAT_LO = {NBYTES{8'h55}};

    always_comb begin
        addr = '0;
        data = '0;
        unique case (step)
            ST_DB_WR, ST_DB_RD: data = DATA_W'(1) << idx;
            ST_AB_WR, ST_AB_RD: begin
                addr = ADDR_W'(1) << idx;
                data = PAT_HI;
            end
            ST_AL_WR: data = PAT_LO;
            ST_AL_RD: begin
                addr = ADDR_W'(1) << idx;
                data = PAT_HI;
            end
            ST_EX_WR, ST_EX_RD: begin
                addr = idx[ADDR_W-1:0];
                data = idx[0] ? PAT_HI : PAT_LO;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mbist_capture.sv
module mbist_capture #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              check,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] exp_val,
    input  logic [DATA_W-1:0] rdata,
    output logic              mismatch,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_got
);
    assign mismatch = check && (rdata != exp_val);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_got  <= '0;
        end else if (mismatch) begin
            fail      <= 1'b1;
            fail_addr <= addr;
            fail_exp  <= exp_val;
            fail_got  <= rdata;
        end
    end
endmodule

// File: rtl/mem_bist.sv
module mem_bist
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              exhaustive,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_got
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SPAN  = (DEPTH > DATA_W) ? DEPTH : DATA_W;
    localparam int IDX_W = $clog2(SPAN) + 1;
    localparam logic [IDX_W-1:0] DB_LAST = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] AB_LAST = IDX_W'(ADDR_W - 1);
    localparam logic [IDX_W-1:0] EX_LAST = IDX_W'(DEPTH - 1);

    step_e             state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic              exh_q, done_q, finish, accept, mismatch;
    logic [DATA_W-1:0] pat_data;

    assign accept = (state_q == ST_IDLE) && start;

    mbist_pattern #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_pat (
        .step (state_q),
        .idx  (idx_q),
        .addr (mem_addr),
        .data (pat_data)
    );

    mbist_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .check     (mem_re && mem_ready),
        .addr      (mem_addr),
        .exp_val   (pat_data),
        .rdata     (mem_rdata),
        .mismatch  (mismatch),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_exp  (fail_exp),
        .fail_got  (fail_got)
    );

    // next-state and index sequencing
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d = ST_DB_WR;
                idx_d   = '0;
            end
            ST_DB_WR: if (mem_ready) state_d = ST_DB_RD;
            ST_DB_RD: if (mem_ready) begin
                if (mismatch) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end else if (idx_q == DB_LAST) begin
                    state_d = ST_AB_WR;
                    idx_d   = '0;
                end else begin
                    state_d = ST_DB_WR;
                    idx_d   = idx_q + 1'b1;
                end
            end
            ST_AB_WR: if (mem_ready) state_d = ST_AB_RD;
            ST_AB_RD: if (mem_ready) begin
                if (mismatch) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end else if (idx_q == AB_LAST) begin
                    state_d = ST_AL_WR;
                    idx_d   = '0;
                end else begin
                    state_d = ST_AB_WR;
                    idx_d   = idx_q + 1'b1;
                end
            end
            ST_AL_WR: if (mem_ready) begin
                state_d = ST_AL_RD;
                idx_d   = '0;
            end
            ST_AL_RD: if (mem_ready) begin
                if (mismatch) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end else if (idx_q == AB_LAST) begin
                    idx_d = '0;
                    if (exh_q) begin
                        state_d = ST_EX_WR;
                    end else begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_EX_WR: if (mem_ready) begin
                if (idx_q == EX_LAST) begin
                    state_d = ST_EX_RD;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_EX_RD: if (mem_ready) begin
                if (mismatch || idx_q == EX_LAST) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            exh_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (accept) begin
                exh_q  <= exhaustive;
                done_q <= 1'b0;
            end else if (finish) begin
                done_q <= 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        mem_we = 1'b0;
        mem_re = 1'b0;
        unique case (state_q)
            ST_DB_WR, ST_AB_WR, ST_AL_WR, ST_EX_WR: mem_we = 1'b1;
            ST_DB_RD, ST_AB_RD, ST_AL_RD, ST_EX_RD: mem_re = 1'b1;
            default: ;
        endcase
        mem_wdata = mem_we ? pat_data : '0;
        busy      = (state_q != ST_IDLE);
        done      = done_q;
    end
endmodule

// File: rtl/mem_bist_chk.sv
module mem_bist_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              mem_re,
    input logic              mem_ready,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [DATA_W-1:0] fail_exp,
    input logic [DATA_W-1:0] fail_got
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    assert_one_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && !mem_ready) |=>
        ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we) && $stable(mem_re)));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=>
        (done && $stable(fail) && $stable(fail_addr) && $stable(fail_exp) && $stable(fail_got)));

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_fail_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> (done && !busy));
endmodule

bind mem_bist mem_bist_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_ready(mem_ready), .busy(busy), .done(done), .fail(fail),
    .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_got(fail_got)
);

// File: tb/sim_mem_bist.sv
module sim_mem_bist;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 16;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int LOG_N   = 2 * DEPTH + 2 * DATA_W + 3 * ADDR_W + 8;
    localparam int T_CLK   = 10;
    localparam logic [DATA_W-1:0] HI = {(DATA_W/8){8'hAA}};
    localparam logic [DATA_W-1:0] LO = {(DATA_W/8){8'h55}};

    logic              clk = 1'b0, rst_n = 1'b0, start = 1'b0, exhaustive = 1'b0;
    logic [ADDR_W-1:0] mem_addr, fail_addr;
    logic [DATA_W-1:0] mem_wdata, fail_exp, fail_got;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              mem_we, mem_re, busy, done, fail;
    logic              mem_ready = 1'b0;

    always #(T_CLK/2) clk = ~clk;

    mem_bist #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .exhaustive(exhaustive),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .done(done),
        .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_got(fail_got)
    );

    int n_chk = 0, n_err = 0;

    // fault model shared by responder and predictor
    logic [DATA_W-1:0] f_stuck_mask = '0, f_stuck_val = '0, f_flip = '0;
    logic [ADDR_W-1:0] f_alias = '0, f_bad_a = '0;

    function automatic logic [ADDR_W-1:0] eff(input logic [ADDR_W-1:0] a);
        return a & ~f_alias;
    endfunction
    function automatic logic [DATA_W-1:0] wval(input logic [DATA_W-1:0] d);
        return (d & ~f_stuck_mask) | (f_stuck_val & f_stuck_mask);
    endfunction
    function automatic logic [DATA_W-1:0] rxor(input logic [ADDR_W-1:0] a);
        return (a == f_bad_a) ? f_flip : '0;
    endfunction

    // predicted run
    logic [DATA_W-1:0] pm [DEPTH];
    logic [ADDR_W-1:0] lg_addr [LOG_N];
    logic [DATA_W-1:0] lg_dat [LOG_N];
    logic              lg_we [LOG_N];
    int                pn;
    logic              pf;
    logic [ADDR_W-1:0] pa;
    logic [DATA_W-1:0] pe, pg;

    task automatic p_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        if (pf) return;
        lg_addr[pn] = a; lg_dat[pn] = d; lg_we[pn] = 1'b1; pn++;
        pm[eff(a)] = wval(d);
    endtask

    task automatic p_rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e);
        logic [DATA_W-1:0] g;
        if (pf) return;
        lg_addr[pn] = a; lg_dat[pn] = '0; lg_we[pn] = 1'b0; pn++;
        g = pm[eff(a)] ^ rxor(a);
        if (g != e) begin
            pf = 1'b1; pa = a; pe = e; pg = g;
        end
    endtask

    task automatic predict(input logic exh);
        pn = 0; pf = 1'b0; pa = '0; pe = '0; pg = '0;
        for (int a = 0; a < DEPTH; a++) pm[a] = '0;
        for (int i = 0; i < DATA_W; i++) begin
            p_wr('0, DATA_W'(1) << i);
            p_rd('0, DATA_W'(1) << i);
        end
        for (int i = 0; i < ADDR_W; i++) begin
            p_wr(ADDR_W'(1) << i, HI);
            p_rd(ADDR_W'(1) << i, HI);
        end
        p_wr('0, LO);
        for (int i = 0; i < ADDR_W; i++) p_rd(ADDR_W'(1) << i, HI);
        if (exh) begin
            for (int a = 0; a < DEPTH; a++) p_wr(ADDR_W'(a), a[0] ? HI : LO);
            for (int a = 0; a < DEPTH; a++) p_rd(ADDR_W'(a), a[0] ? HI : LO);
        end
    endtask

    // responder memory
    logic [DATA_W-1:0] bm [DEPTH];
    int acc_n = 0, seq_err = 0;

    always @(posedge clk) begin
        if (rst_n && mem_ready && (mem_we || mem_re)) begin
            if (acc_n >= pn || mem_addr != lg_addr[acc_n] || mem_we != lg_we[acc_n] ||
                (mem_we && mem_wdata != lg_dat[acc_n]))
                seq_err++;
            if (mem_we) bm[eff(mem_addr)] <= wval(mem_wdata);
            acc_n++;
        end
    end

    always @(negedge clk) begin
        mem_ready <= ($urandom % 4) != 0;
        mem_rdata <= bm[eff(mem_addr)] ^ rxor(mem_addr);
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_faults();
        f_stuck_mask = '0; f_stuck_val = '0; f_flip = '0; f_alias = '0; f_bad_a = '0;
    endtask

    // one run: predict, start, wait, compare; optional mid-run second start
    task automatic run(input logic exh, input bit poke);
        int guard;
        logic [ADDR_W-1:0] ha;
        predict(exh);
        for (int a = 0; a < DEPTH; a++) bm[a] = '0;
        acc_n = 0; seq_err = 0;
        @(negedge clk);
        exhaustive = exh; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done && !fail, "R2 busy after start", {busy, done, fail}, 3'b100);
        exhaustive = ~exh;
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 20000, "R10 watchdog", guard, 0);
        chk(!busy && done, "R10 done and idle", {busy, done}, 2'b01);
        chk(fail == pf, "R6 fail flag", fail, pf);
        chk(acc_n == pn, poke ? "R9 access count" : "R5 access count", acc_n, pn);
        chk(seq_err == 0, "R7 access order", seq_err, 0);
        chk(fail_addr == pa, "R6 fail_addr", fail_addr, pa);
        chk(fail_exp == pe, "R6 fail_exp", fail_exp, pe);
        chk(fail_got == pg, "R6 fail_got", fail_got, pg);
        ha = fail_addr;
        repeat (6) @(negedge clk);
        chk(fail_addr == ha && done && fail == pf && acc_n == pn, "R8 results held",
            fail_addr, ha);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int a = 0; a < DEPTH; a++) bm[a] = '0;
        pn = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail && !mem_we && !mem_re, "R1 reset state",
            {busy, done, fail, mem_we, mem_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 clean memory, short run
        clear_faults(); run(1'b0, 0);
        // R5 clean memory with full sweep
        clear_faults(); run(1'b1, 0);
        // R2 stuck data bit fails the walking-bit phase
        clear_faults(); f_stuck_mask = DATA_W'(1) << 5; run(1'b0, 0);
        chk(pa == '0 && pf, "R2 data-bus fault located", pa, 0);
        // R4 dropped address bit caught only by alias phase
        clear_faults(); f_alias = ADDR_W'(8); run(1'b1, 0);
        chk(fail_addr == ADDR_W'(8) && fail_got == LO, "R4 alias found at 8", fail_addr, 8);
        // R5 corrupt odd cell found by sweep
        clear_faults(); f_bad_a = ADDR_W'(8'h37); f_flip = DATA_W'(16'h0100); run(1'b1, 0);
        chk(fail_addr == ADDR_W'(8'h37) && fail_exp == HI, "R5 sweep fault", fail_addr, 8'h37);
        // R5 same cell, no sweep requested: passes
        run(1'b0, 0);
        chk(!fail && fail_addr == '0, "R8 cleared by start", fail_addr, 0);
        // R9 extra start while busy
        clear_faults(); run(1'b0, 1);
        // R3 R6 random faults
        for (int it = 0; it < 8; it++) begin
            int kind;
            clear_faults();
            kind = $urandom % 3;
            if (kind == 0) begin
                f_stuck_mask = DATA_W'(1) << ($urandom % DATA_W);
                f_stuck_val  = DATA_W'($urandom);
            end else if (kind == 1) begin
                f_alias = ADDR_W'(1) << ($urandom % ADDR_W);
            end else begin
                f_bad_a = ADDR_W'($urandom);
                f_flip  = DATA_W'(1) << ($urandom % DATA_W);
            end
            run(1'($urandom % 2), 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule